// File: doc/BRIEF.md
# PCI Configuration Header with Parity Error Reporting

This block holds the first two dwords of a Type 0 configuration header for a network function: the vendor and device identification words, the Command register and the Status register. The bus interface hands it decoded configuration read and write strobes with a dword index, byte enables and 32-bit write data. Reads return data one clock after the strobe.

The block also receives single-cycle parity events from the bus interface: address parity error, data parity error and a flag saying the current cycle is one the function mastered. The Command enables decide whether these events raise a PERR request, a SERR request, or only status flags. Both requests are one-clock pulses that an external pin driver stretches.

The device identification word can be replaced from a serial-memory loader through a dedicated load port. Two resets exist. The hard reset clears everything. The soft reset clears the decode, master and parity response enables but keeps the system-error enable.

Top module: `pci_cfg_hdr`

## Requirements
- R1: After hard reset (`rst_n` low at a clock edge), the following hold. The Command and Status registers read 0. The device ID reads the `DEVICE_ID_RST` parameter. `cfg_rdata`, `perr_req`, `serr_req` and all enable outputs are 0.
- R2: Dword 0 bits 15:0 read the `VENDOR_ID` parameter. Host writes to dword 0 never change it.
- R3: Dword 0 bits 31:16 hold the device ID. Host writes never change it. A pulse on `ee_load` replaces it with `ee_devid` from the next clock on.
- R4: The Command register is dword 1 bits 15:0. Only five bits are writable: bit 0 (I/O decode), bit 1 (memory decode), bit 2 (bus master), bit 6 (parity error response) and bit 8 (system error enable). Every other Command bit reads 0, including reserved bits 15:10 and 7 and fast back-to-back bit 9. Writing 0 turns all enables off.
- R5: Byte enables qualify every write. `cfg_be[0]` covers Command bits 7:0. `cfg_be[1]` covers Command bits 15:8. `cfg_be[3]` covers the Status error bits in dword bits 31:24. A lane whose enable is 0 is left unchanged.
- R6: A data or address parity event sets Status bit 15 (dword bit 31, detected parity error), whatever the enables are.
- R7: A data parity event while Command bit 6 is 1 produces a one-clock `perr_req` on the next clock. While bit 6 is 0, no `perr_req` follows.
- R8: Status bit 8 (dword bit 24, data parity reported) is set by a data parity event only when Command bit 6 is 1 and `master_cycle` is 1.
- R9: An address parity event while Command bits 8 and 6 are both 1 produces a one-clock `serr_req` on the next clock. It also sets Status bit 14 (dword bit 30, signaled system error). In any other case there is no `serr_req` and bit 14 is unchanged.
- R10: Status error bits are write-one-to-clear. A 1 clears the bit and a 0 leaves it alone. An event that sets a bit in the same clock as its clear leaves the bit set.
- R11: `soft_rst` clears Command bits 0, 1, 2 and 6, overriding a write in the same clock. It leaves bit 8 and the Status register unchanged.
- R12: A read strobe loads `cfg_rdata` at the next clock with the addressed dword, using the state from before that clock. Dword indices other than 0 and 1 read 0. Without a strobe, `cfg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | DW_ADDR_W | Dword index in configuration space |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ee_load | input | 1 | Device ID load strobe from the serial-memory loader |
| ee_devid | input | 16 | Device ID value to load |
| data_perr | input | 1 | Data parity error detected this clock |
| addr_perr | input | 1 | Address parity error detected this clock |
| master_cycle | input | 1 | Current cycle was mastered by this function |
| perr_req | output | 1 | One-clock PERR request |
| serr_req | output | 1 | One-clock SERR request |
| io_en | output | 1 | I/O space decode enable |
| mem_en | output | 1 | Memory space decode enable |
| bus_master_en | output | 1 | Bus master enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | System error enable |

## Verification
The hardest cases to produce are the same-clock collisions. One is a parity event that lands on the clock of a write-one-to-clear of the bit it sets. Another is a soft reset that coincides with a Command write, where the system-error enable must survive while the other enables drop. A system-error request also needs both the system-error and parity response enables set before the address event arrives. The stimulus first drives each collision as a directed sequence. It then runs a long random phase with dense parity events, frequent Command writes that often leave both enables set, and occasional soft resets and loads, all compared against a bench model built from the requirements.

// File: rtl/pci_cfg_pkg.sv
// Shared constants for the configuration header: dword indices and bit positions
// that software and the rest of the device rely on.
package pci_cfg_pkg;
    localparam int unsigned DW_ID   = 0;   // identification dword
    localparam int unsigned DW_CMST = 1;   // command/status dword

    localparam int unsigned CMD_IO  = 0;
    localparam int unsigned CMD_MEM = 1;
    localparam int unsigned CMD_MST = 2;
    localparam int unsigned CMD_PER = 6;
    localparam int unsigned CMD_SER = 8;

    localparam int unsigned ST_DPR  = 8;
    localparam int unsigned ST_SSE  = 14;
    localparam int unsigned ST_DPE  = 15;

    localparam logic [15:0] CMD_WMASK = (16'h1 << CMD_IO) | (16'h1 << CMD_MEM) |
                                        (16'h1 << CMD_MST) | (16'h1 << CMD_PER) |
                                        (16'h1 << CMD_SER);
    localparam logic [15:0] CMD_KEEP_SOFT = 16'h1 << CMD_SER;
    localparam logic [15:0] ST_MASK = (16'h1 << ST_DPR) | (16'h1 << ST_SSE) |
                                      (16'h1 << ST_DPE);
endpackage

// File: rtl/pci_cfg_cmd.sv
// Command register. Holds only the implemented enable bits; other bits stay zero.
// Assumes: wr_hit is already qualified by the dword decode; soft_rst wins over a write.
module pci_cfg_cmd
    import pci_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        wr_hit,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output logic [15:0] cmd_q
);
    logic [15:0] cmd_d;

    // Next value: byte-lane merge, implemented-bit mask, then soft reset clear.
    always_comb begin
        cmd_d = cmd_q;
        if (wr_hit) begin
            for (int b = 0; b < 2; b++) begin
                if (be[b]) cmd_d[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
        cmd_d = cmd_d & CMD_WMASK;
        if (soft_rst) cmd_d = cmd_d & CMD_KEEP_SOFT;
    end

    // State register, cleared only by hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end
endmodule

// File: rtl/pci_cfg_err.sv
// Status error flags and PERR/SERR request pulses.
// Assumes: parity events are one-clock pulses and the enables are the registered
// Command bits, so gating uses the values held before the event's clock edge.
module pci_cfg_err
    import pci_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    input  logic        data_perr,
    input  logic        addr_perr,
    input  logic        master_cycle,
    input  logic        perr_en,
    input  logic        serr_en,
    output logic [15:0] status_q,
    output logic        perr_req,
    output logic        serr_req
);
    logic [15:0] set_v;
    logic [15:0] clr_v;
    logic        sse_ev;

    // Events that set status flags this clock.
    always_comb begin
        sse_ev = addr_perr && serr_en && perr_en;
        set_v  = '0;
        set_v[ST_DPE] = data_perr || addr_perr;
        set_v[ST_SSE] = sse_ev;
        set_v[ST_DPR] = data_perr && perr_en && master_cycle;
    end

    // Write-one-to-clear vector, qualified per byte lane.
    always_comb begin
        clr_v = '0;
        if (wr_hit) begin
            for (int b = 0; b < 2; b++) begin
                if (be[b]) clr_v[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    // Status flags: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_v) | set_v) & ST_MASK;
    end

    // Request pulses, one clock after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_req <= 1'b0;
            serr_req <= 1'b0;
        end else begin
            perr_req <= data_perr && perr_en;
            serr_req <= sse_ev;
        end
    end
endmodule

// File: rtl/pci_cfg_hdr.sv
// Top of the configuration header: identification words, read mux and the
// Command/Status sub-blocks. Assumes decoded strobes and a dword index.
module pci_cfg_hdr
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID_RST = 16'h3C4D,
    parameter int unsigned DW_ADDR_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [DW_ADDR_W-1:0] cfg_dw_addr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 ee_load,
    input  logic [15:0]          ee_devid,
    input  logic                 data_perr,
    input  logic                 addr_perr,
    input  logic                 master_cycle,
    output logic                 perr_req,
    output logic                 serr_req,
    output logic                 io_en,
    output logic                 mem_en,
    output logic                 bus_master_en,
    output logic                 perr_resp_en,
    output logic                 serr_en
);
    localparam logic [DW_ADDR_W-1:0] A_ID   = DW_ADDR_W'(DW_ID);
    localparam logic [DW_ADDR_W-1:0] A_CMST = DW_ADDR_W'(DW_CMST);

    logic        hit_cmst;
    logic [15:0] cmd_q;
    logic [15:0] status_q;
    logic [15:0] devid_q;
    logic [31:0] rd_mux;

    assign hit_cmst = cfg_wr && (cfg_dw_addr == A_CMST);

    pci_cfg_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_hit   (hit_cmst),
        .be       (cfg_be[1:0]),
        .wdata    (cfg_wdata[15:0]),
        .cmd_q    (cmd_q)
    );

    pci_cfg_err u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (hit_cmst),
        .be           (cfg_be[3:2]),
        .wdata        (cfg_wdata[31:16]),
        .data_perr    (data_perr),
        .addr_perr    (addr_perr),
        .master_cycle (master_cycle),
        .perr_en      (cmd_q[CMD_PER]),
        .serr_en      (cmd_q[CMD_SER]),
        .status_q     (status_q),
        .perr_req     (perr_req),
        .serr_req     (serr_req)
    );

    // Device ID: host read-only, replaced by the loader strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       devid_q <= DEVICE_ID_RST;
        else if (ee_load) devid_q <= ee_devid;
    end

    // Read selection by dword index; unmapped dwords read zero.
    always_comb begin
        unique case (cfg_dw_addr)
            A_ID:    rd_mux = {devid_q, VENDOR_ID};
            A_CMST:  rd_mux = {status_q, cmd_q};
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= rd_mux;
    end

    assign io_en         = cmd_q[CMD_IO];
    assign mem_en        = cmd_q[CMD_MEM];
    assign bus_master_en = cmd_q[CMD_MST];
    assign perr_resp_en  = cmd_q[CMD_PER];
    assign serr_en       = cmd_q[CMD_SER];
endmodule

// File: rtl/pci_cfg_hdr_chk.sv
// Protocol checker for pci_cfg_hdr: request pulses against their causes, and
// the soft reset effect on the enables. Attached by bind below.
module pci_cfg_hdr_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic cfg_wr,
    input logic data_perr,
    input logic addr_perr,
    input logic perr_req,
    input logic serr_req,
    input logic io_en,
    input logic mem_en,
    input logic bus_master_en,
    input logic perr_resp_en,
    input logic serr_en
);
    p_perr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        perr_req |-> $past(data_perr && perr_resp_en));

    p_perr_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_perr && perr_resp_en) |=> perr_req);

    p_serr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> $past(addr_perr && serr_en && perr_resp_en));

    p_serr_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_perr && serr_en && perr_resp_en) |=> serr_req);

    p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !(io_en || mem_en || bus_master_en || perr_resp_en));

    p_soft_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !cfg_wr) |=> $stable(serr_en));
endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk u_chk (.*);

// File: tb/pci_cfg_hdr_tb.sv
`timescale 1ns/1ps
module pci_cfg_hdr_tb;
    localparam logic [15:0] VEN = 16'h1A2B;
    localparam logic [15:0] DEV = 16'h3C4D;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst, cfg_wr, cfg_rd, ee_load;
    logic [5:0]  cfg_dw_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [15:0] ee_devid;
    logic        data_perr, addr_perr, master_cycle;
    logic        perr_req, serr_req, io_en, mem_en, bus_master_en, perr_resp_en, serr_en;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [15:0] m_cmd, m_dev;
    logic [2:0]  m_st;      // {dpe, sse, dpr}
    logic        m_perr, m_serr;
    logic [31:0] m_rdata;

    always #2 clk = ~clk;

    pci_cfg_hdr #(.VENDOR_ID(VEN), .DEVICE_ID_RST(DEV), .DW_ADDR_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ee_load(ee_load), .ee_devid(ee_devid),
        .data_perr(data_perr), .addr_perr(addr_perr), .master_cycle(master_cycle),
        .perr_req(perr_req), .serr_req(serr_req), .io_en(io_en), .mem_en(mem_en),
        .bus_master_en(bus_master_en), .perr_resp_en(perr_resp_en), .serr_en(serr_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'd0:    return {m_dev, VEN};
            6'd1:    return {m_st[2], m_st[1], 5'b0, m_st[0], 8'b0, m_cmd};
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle();
        soft_rst = 0; cfg_wr = 0; cfg_rd = 0; cfg_dw_addr = 0; cfg_be = 0; cfg_wdata = 0;
        ee_load = 0; ee_devid = 0; data_perr = 0; addr_perr = 0; master_cycle = 0;
    endtask

    // One clock: predict from inputs set at this negedge, then compare at the next one.
    task automatic step();
        logic [15:0] n_cmd;
        logic [2:0]  set_v, clr_v, n_st;
        logic        hit;
        logic [31:0] n_rd;
        logic [15:0] n_dev;
        logic        n_perr, n_serr;
        hit   = cfg_wr && (cfg_dw_addr == 6'd1);
        n_cmd = m_cmd;
        if (hit && cfg_be[0]) n_cmd[7:0]  = cfg_wdata[7:0];
        if (hit && cfg_be[1]) n_cmd[15:8] = cfg_wdata[15:8];
        n_cmd = n_cmd & 16'h0147;
        if (soft_rst) n_cmd = n_cmd & 16'h0100;
        set_v = {data_perr || addr_perr, addr_perr && m_cmd[8] && m_cmd[6],
                 data_perr && m_cmd[6] && master_cycle};
        clr_v = (hit && cfg_be[3]) ? {cfg_wdata[31], cfg_wdata[30], cfg_wdata[24]} : 3'b0;
        n_st   = (m_st & ~clr_v) | set_v;
        n_perr = data_perr && m_cmd[6];
        n_serr = set_v[1];
        n_dev  = ee_load ? ee_devid : m_dev;
        n_rd   = cfg_rd ? exp_read(cfg_dw_addr) : m_rdata;
        @(posedge clk);
        @(negedge clk);
        m_cmd = n_cmd; m_st = n_st; m_perr = n_perr; m_serr = n_serr;
        m_dev = n_dev; m_rdata = n_rd;
        idle();
        check("R7 perr_req", {31'b0, perr_req}, {31'b0, m_perr});
        check("R9 serr_req", {31'b0, serr_req}, {31'b0, m_serr});
        check("R4/R11 enables", {27'b0, io_en, mem_en, bus_master_en, perr_resp_en, serr_en},
              {27'b0, m_cmd[0], m_cmd[1], m_cmd[2], m_cmd[6], m_cmd[8]});
        check("R12 cfg_rdata", cfg_rdata, m_rdata);
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
        step();
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        cfg_rd = 1; cfg_dw_addr = a;
        step();
        d = cfg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_cmd = 0; m_st = 0; m_dev = DEV; m_perr = 0; m_serr = 0; m_rdata = 0;
        // R1 reset state
        check("R1 rdata after reset", cfg_rdata, 32'h0);
        check("R1 enables after reset",
              {27'b0, io_en, mem_en, bus_master_en, perr_resp_en, serr_en}, 32'h0);
        rd(6'd1, d); check("R1 cmd/status reset", d, 32'h0);
        rd(6'd0, d); check("R1 R2 id after reset", d, {DEV, VEN});
        // R2 R3 host writes to identification ignored
        wr(6'd0, 4'hF, 32'hFFFF_FFFF);
        rd(6'd0, d); check("R2 R3 id write ignored", d, {DEV, VEN});
        // R4 only implemented bits stick
        wr(6'd1, 4'h3, 32'h0000_FFFF);
        rd(6'd1, d); check("R4 command mask", d, 32'h0000_0147);
        wr(6'd1, 4'h3, 32'h0);
        check("R4 zero write disables", {29'b0, io_en, mem_en, bus_master_en}, 32'h0);
        // R3 loader
        ee_load = 1; ee_devid = 16'hBEEF; step();
        rd(6'd0, d); check("R3 device id load", d, {16'hBEEF, VEN});
        // R6 R7 parity without response enable
        data_perr = 1; master_cycle = 1; step();
        check("R7 no perr when disabled", {31'b0, perr_req}, 32'h0);
        rd(6'd1, d); check("R6 R8 dpe only", d, 32'h8000_0000);
        // R8 master data parity with response enabled
        wr(6'd1, 4'hB, 32'h8000_0140);  // also clears dpe (R10)
        data_perr = 1; master_cycle = 1; step();
        check("R7 perr pulse", {31'b0, perr_req}, 32'h1);
        step();
        check("R7 perr one clock", {31'b0, perr_req}, 32'h0);
        rd(6'd1, d); check("R8 dpr set", d, 32'h8100_0140);
        // R9 address parity with both enables
        addr_perr = 1; step();
        check("R9 serr pulse", {31'b0, serr_req}, 32'h1);
        rd(6'd1, d); check("R9 sse set", d, 32'hC100_0140);
        // R10 clear collides with a new detected parity event
        cfg_wr = 1; cfg_dw_addr = 1; cfg_be = 4'h8; cfg_wdata = 32'hC100_0000;
        data_perr = 1; step();
        rd(6'd1, d); check("R10 set wins over clear", d, 32'h8000_0140);
        // R5 upper lane only: command untouched
        wr(6'd1, 4'h8, 32'hFFFF_0000);
        rd(6'd1, d); check("R5 upper lane only", d, 32'h0000_0140);
        // R11 soft reset together with a write
        wr(6'd1, 4'h3, 32'h0000_0147);
        soft_rst = 1; cfg_wr = 1; cfg_dw_addr = 1; cfg_be = 4'h3; cfg_wdata = 32'h0000_0007;
        step();
        rd(6'd1, d); check("R11 soft reset wins", d, 32'h0);
        wr(6'd1, 4'h3, 32'h0000_0147);
        soft_rst = 1; step();
        rd(6'd1, d); check("R11 serr_en kept", d, 32'h0000_0100);
        rd(6'd9, d); check("R12 unmapped reads zero", d, 32'h0);
        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cfg_wr = (r[1:0] == 2'd0);
            case (r[3:2])
                2'd0: cfg_dw_addr = 6'd0;
                2'd1, 2'd2: cfg_dw_addr = 6'd1;
                default: cfg_dw_addr = 6'd15;
            endcase
            cfg_be       = r[7:4];
            cfg_rd       = r[8];
            data_perr    = (r[11:9] == 3'd0);
            addr_perr    = (r[14:12] == 3'd0);
            master_cycle = r[15];
            soft_rst     = (r[20:16] == 5'd0);
            ee_load      = (r[25:21] == 5'd0);
            ee_devid     = $urandom;
            cfg_wdata    = $urandom;
            if (r[26]) cfg_wdata[8] = 1'b1;
            if (r[27]) cfg_wdata[6] = 1'b1;
            step();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule